// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This unit keeps the eight-bit status byte of a serial memory and decides, every cycle, whether a memory write to the currently addressed byte may proceed and whether a status-byte update may proceed. A command decoder in front of it raises one-cycle strobes for set-enable, clear-enable, load-status and snapshot-status. A separate level input tells the unit whether the external protect pin is high.

Two bits of the status byte choose how much of the upper address space is locked: none, the top quarter, the top half, or all of it. An enable latch must be set before any write is permitted. A lock bit, together with the protect pin, can freeze the status byte itself. The status flops model non-volatile storage, so only the power-on reset input clears them. The memory array and the serial shifter sit outside this unit.

Top module: `sr_guard`

## Requirements
- R1: After power-on reset, `sr_out`, `rd_byte`, `mem_wr_ok` and `stat_wr_ok` are all zero.
- R2: The enable latch is bit 1 of `sr_out`. A `cmd_wen` strobe sets it on the next clock edge, and a `cmd_wdis` strobe clears it on the next clock edge. If both strobes arrive in the same cycle, the clear wins.
- R3: While the enable latch is 0, both `mem_wr_ok` and `stat_wr_ok` are 0, whatever the other status bits, `prot_pin` and `addr` are.
- R4: While the enable latch is 1, `stat_wr_ok` is 1 when the lock bit (bit 7) is 0. When the lock bit is 1, `stat_wr_ok` follows `prot_pin`.
- R5: A `cmd_wsr` strobe while `stat_wr_ok` is 1 loads bits 7, 6, 5, 4, 3, 2 and 0 of `wsr_data` into `sr_out` on the next edge. Bit 1 is never taken from `wsr_data`.
- R6: A `cmd_wsr` strobe while `stat_wr_ok` is 0 leaves every bit of `sr_out` unchanged.
- R7: With the enable latch at 1, the region bits (bits 3:2) select the locked region, and `mem_wr_ok` is 1 only outside it. The encodings are: 00 locks nothing; 01 locks addresses whose top two bits are 11; 10 locks addresses whose top bit is 1; 11 locks every address.
- R8: Bits 6, 5, 4 and 0 have no effect on `mem_wr_ok` or `stat_wr_ok`.
- R9: A `cmd_rsr` strobe copies the current `sr_out` into `rd_byte` on the next edge. At all other times `rd_byte` holds its value.
- R10: When `cmd_wsr` and `cmd_wen` arrive in the same cycle, the status load is judged with the enable latch value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| cmd_wen | input | 1 | Set-enable strobe |
| cmd_wdis | input | 1 | Clear-enable strobe |
| cmd_wsr | input | 1 | Load-status strobe |
| cmd_rsr | input | 1 | Snapshot-status strobe |
| wsr_data | input | 8 | Byte offered for a status load |
| prot_pin | input | 1 | Protect pin level, high allows updates to a locked status byte |
| addr | input | ADDR_W | Target byte address of a pending memory write |
| sr_out | output | 8 | Live status byte |
| rd_byte | output | 8 | Status snapshot for readback |
| mem_wr_ok | output | 1 | Memory write to `addr` is permitted |
| stat_wr_ok | output | 1 | Status load is permitted |

## Verification
The bench aims at the region boundaries: 0x0FFFF/0x10000 for the half region and 0x17FFF/0x18000 for the quarter region. A decoder that used the wrong address bits would wrongly permit or block writes on one side of each boundary. It drives a status load with the lock set and the pin low, where a design that ignored the pin would corrupt the region bits. It also tries a load offering a 0 in bit 1 while the enable latch is set; a design that took bit 1 from the byte would drop the enable. Collisions of enable and load strobes, and of clear and set strobes, expose designs that use the post-edge latch or the wrong priority.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cmd_wen,
  input  logic              cmd_wdis,
  input  logic              cmd_wsr,
  input  logic              cmd_rsr,
  input  logic [7:0]        wsr_data,
  input  logic              prot_pin,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        sr_out,
  output logic [7:0]        rd_byte,
  output logic              mem_wr_ok,
  output logic              stat_wr_ok
);

  localparam int          BIT_LOCK = 7;
  localparam int          BIT_RHI  = 3;
  localparam int          BIT_RLO  = 2;
  localparam int          BIT_EN   = 1;
  localparam logic [7:0]  LOAD_MSK = ~(8'd1 << BIT_EN);

  logic [7:0] sr_q, sr_d, rd_q;
  logic       en_l, lock_l, in_region;
  logic [1:0] region;

  assign en_l   = sr_q[BIT_EN];
  assign lock_l = sr_q[BIT_LOCK];
  assign region = sr_q[BIT_RHI:BIT_RLO];

  always_comb begin
    case (region)
      2'b00:   in_region = 1'b0;
      2'b01:   in_region = &addr[ADDR_W-1:ADDR_W-2];
      2'b10:   in_region = addr[ADDR_W-1];
      default: in_region = 1'b1;
    endcase
  end

  assign stat_wr_ok = en_l & (~lock_l | prot_pin);
  assign mem_wr_ok  = en_l & ~in_region;

  always_comb begin
    sr_d = sr_q;
    if (cmd_wsr && stat_wr_ok) sr_d = (sr_q & ~LOAD_MSK) | (wsr_data & LOAD_MSK);
    if (cmd_wen)  sr_d[BIT_EN] = 1'b1;
    if (cmd_wdis) sr_d[BIT_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sr_q <= '0;
      rd_q <= '0;
    end else begin
      sr_q <= sr_d;
      if (cmd_rsr) rd_q <= sr_q;
    end
  end

  assign sr_out  = sr_q;
  assign rd_byte = rd_q;

  AST_EN_SET: assert property (@(posedge clk) disable iff (!por_n)
    cmd_wen && !cmd_wdis |=> sr_out[BIT_EN]); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!por_n)
    cmd_wdis |=> !sr_out[BIT_EN]); // R2
  AST_NO_EN_NO_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    !sr_out[BIT_EN] |-> !mem_wr_ok && !stat_wr_ok); // R3
  AST_LOCK_PIN_LOW: assert property (@(posedge clk) disable iff (!por_n)
    sr_out[BIT_LOCK] && !prot_pin |-> !stat_wr_ok); // R4
  AST_LOAD_BITS: assert property (@(posedge clk) disable iff (!por_n)
    cmd_wsr && stat_wr_ok |=> (sr_out & LOAD_MSK) == ($past(wsr_data) & LOAD_MSK)); // R5
  AST_BLOCKED_LOAD_STABLE: assert property (@(posedge clk) disable iff (!por_n)
    cmd_wsr && !stat_wr_ok |=> $stable(sr_out & LOAD_MSK)); // R6
  AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
    sr_out[BIT_RHI:BIT_RLO] == 2'b11 |-> !mem_wr_ok); // R7
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!por_n)
    cmd_rsr |=> rd_byte == $past(sr_out)); // R9
  AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !cmd_rsr |=> $stable(rd_byte)); // R9

endmodule

// File: tb/sr_guard_bench.sv
module sr_guard_bench;
  localparam int CLK_NS = 10;
  localparam int AW = 17;

  logic clk = 0, por_n = 0;
  logic wen = 0, wdis = 0, wsr = 0, rsr = 0, pin = 0;
  logic [7:0] wdat = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0] sr_out, rd_byte;
  logic mem_ok, st_ok;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_sr = 0, m_rd = 0;

  always #(CLK_NS/2) clk = ~clk;

  sr_guard #(.ADDR_W(AW)) u_sr_guard (
    .clk(clk), .por_n(por_n), .cmd_wen(wen), .cmd_wdis(wdis), .cmd_wsr(wsr),
    .cmd_rsr(rsr), .wsr_data(wdat), .prot_pin(pin), .addr(addr),
    .sr_out(sr_out), .rd_byte(rd_byte), .mem_wr_ok(mem_ok), .stat_wr_ok(st_ok));

  function automatic logic f_st_ok(logic [7:0] s, logic p);
    return s[1] && (!s[7] || p);
  endfunction

  function automatic logic f_mem_ok(logic [7:0] s, logic [AW-1:0] a);
    logic hit;
    case (s[3:2])
      2'b00: hit = 0;
      2'b01: hit = (a[AW-1] && a[AW-2]);
      2'b10: hit = a[AW-1];
      default: hit = 1;
    endcase
    return s[1] && !hit;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic i_wen, logic i_wdis, logic i_wsr, logic i_rsr,
                     logic [7:0] d, logic p, logic [AW-1:0] a, string tg);
    logic [7:0] nx;
    logic ok;
    @(negedge clk);
    wen = i_wen; wdis = i_wdis; wsr = i_wsr; rsr = i_rsr; wdat = d; pin = p; addr = a;
    #1;
    ok = f_st_ok(m_sr, p);
    chk(tg != "" ? tg : (m_sr[1] ? "R4" : "R3"), st_ok, ok);
    chk(tg != "" ? tg : (m_sr[1] ? "R7" : "R3"), mem_ok, f_mem_ok(m_sr, a));
    nx = m_sr;
    if (i_wsr && ok) nx = {d[7:2], m_sr[1], d[0]};
    if (i_wen) nx[1] = 1;
    if (i_wdis) nx[1] = 0;
    if (i_rsr) m_rd = m_sr;
    @(posedge clk); #1;
    m_sr = nx;
    chk(tg != "" ? tg : (i_wsr ? (ok ? "R5" : "R6") : "R2"), sr_out, m_sr);
    chk(tg != "" ? tg : "R9", rd_byte, m_rd);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_NS*2 + 1);
    chk("R1", {sr_out, rd_byte, 6'd0, mem_ok, st_ok}, 32'd0);
    @(negedge clk); por_n = 1;
    // R3: nothing allowed before enable
    cyc(0,0,1,0,8'h8C,1,17'h00000,"R3");
    cyc(1,0,0,0,0,0,0,"R2");
    // R7 boundaries for each region setting
    cyc(0,0,1,0,8'h04,0,0,"R5");
    cyc(0,0,0,0,0,0,17'h17FFF,"R7");
    cyc(0,0,0,0,0,0,17'h18000,"R7");
    cyc(0,0,1,0,8'h08,0,0,"R5");
    cyc(0,0,0,0,0,0,17'h0FFFF,"R7");
    cyc(0,0,0,0,0,0,17'h10000,"R7");
    cyc(0,0,1,0,8'h0C,0,17'h00000,"R7");
    cyc(0,0,0,0,0,0,17'h00000,"R7");
    // R5: offered bit1 = 0 must not drop enable
    cyc(0,0,1,0,8'h00,0,17'h1FFFF,"R5");
    // R8: user bits do not change permits
    cyc(0,0,1,0,8'h71,0,17'h1FFFF,"R8");
    cyc(0,0,0,1,0,1,17'h1FFFF,"R8");
    // R4/R6: lock with pin low blocks, pin high allows
    cyc(0,0,1,0,8'h84,1,0,"R5");
    cyc(0,0,1,0,8'h0C,0,0,"R6");
    cyc(0,0,1,0,8'h00,1,0,"R4");
    // R2: clear wins over set
    cyc(1,1,0,0,0,0,0,"R2");
    // R10: load together with set while latch clear is not applied
    cyc(1,0,1,0,8'hFF,1,0,"R10");
    cyc(0,0,0,1,0,0,0,"R9");
    cyc(0,0,0,0,0,0,0,"R9");
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [AW-1:0] a;
      k = $urandom_range(0, 9);
      a = AW'($urandom);
      if ($urandom_range(0,3) == 0) a = {2'b11, {(AW-2){1'b0}}} - AW'($urandom_range(0,1));
      cyc(k < 3, k == 3, k >= 4 && k < 8, k == 8 || $urandom_range(0,4) == 0,
          8'($urandom), 1'($urandom), a, "");
    end
    @(negedge clk); wen = 0; wdis = 0; wsr = 0; rsr = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule